// File: doc/BRIEF.md
# Port Interrupt Status and Steering Controller

This block collects interrupt events for a group of storage ports and presents them to software through a small register window. Each port latches single-cycle event pulses into sticky raw bits. It shows those bits twice in one 32-bit status word: once gated by the port's enable mask in the low half, and once ungated in the upper half. Software acknowledges events by writing the status value it read back to the status offset. Every bit written as one, in either half, clears the matching latched event.

Each port keeps an enable mask with separate set and clear write offsets. Both offsets also carry a 2-bit steering field. Each port drives an interrupt line that is high while any enabled event is pending. A host level adds a summary word with one pending bit per port and a control mask that decides which ports reach the single host interrupt output.

Register map: the host region is at region 0 (address bits [11:8] = 0), with the summary word at 0x000 and host control at 0x004. Port p sits in region p+1, so port 0 is at 0x100 and port 3 at 0x400. Inside a port, the status word is at offset 0x08, enable-set at 0x10 and enable-clear at 0x14. Reads are combinational on the address. Writes take effect at the clock edge on which `bus_wr` is high.

Top module: `irqc_host_top`

## Requirements
- R1: After reset every latched event, every enable bit, every steering field and the host control mask are zero. All status and enable reads then return 0, and `port_irq` and `host_irq` are low.
- R2: A pulse on event input bit i of port p is latched when i is an assigned event position (0 to 6 or 11). From the next cycle, status bit i+16 of that port reads one, and it stays set until it is cleared. Pulses on positions 7 to 10 are ignored, and those status bits always read zero.
- R3: Status bits [11:0] read as the latched events ANDed with the enable mask. Bits [15:12] and [31:28] read zero.
- R4: A write to offset 0x10 ORs wdata bits [11:0] (assigned positions only) into the enable mask and ORs wdata [31:30] into the steering field. A write to offset 0x14 clears the enable and steering bits written as one. A read of 0x10 or 0x14 returns {steering, 18'b0, enable}.
- R5: A write to offset 0x08 clears every latched event i for which wdata bit i or wdata bit i+16 is one, so writing back a value just read acknowledges all that was read.
- R6: When an event pulse and a status clear hit the same bit in the same cycle, the bit stays set.
- R7: `port_irq[p]` is the OR of port p's masked status bits.
- R8: The summary word at 0x000 has bit p equal to `port_irq[p]`, and all its other bits read zero.
- R9: Host control at 0x004 holds one enable bit per port in bits [N_PORTS-1:0] and reads back. `host_irq` is the OR of `port_irq` ANDed with that mask. While the mask is zero, `host_irq` stays low and port events still latch.
- R10: A write to one port's region changes no other port. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | N_PORTS*12 | Event pulses, 12 bits per port, port p at [12p+11:12p] |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| port_irq | output | N_PORTS | Per-port interrupt lines |
| host_irq | output | 1 | Combined host interrupt |

## Verification
The bench clears status through the masked half and, separately, through the raw half. A design that decoded only one half would leave the event pending. It writes an unmasked status value back and expects zero, and it fires an event in the same cycle as its clear. A design that gave the clear priority would lose that event. It sets and then partially clears the steering field together with the enable bits, and it writes the unassigned positions 7 to 10 to show they never latch or enable. It also holds the host mask at zero while a port is pending, then walks the mask across ports, to catch a host output that leaks past the mask or a summary word that is wrongly gated by it.

// File: rtl/irqc_pkg.sv
// Shared constants for the port interrupt controller.
// Assumes 32-bit register data and 12 event positions per port.
package irqc_pkg;
    localparam int EVT_W     = 12;
    localparam int RAW_LSB   = 16;
    localparam int STEER_LSB = 30;
    localparam int STEER_W   = 2;
    localparam int DATA_W    = 32;
    // Assigned event positions: 0..6 and 11
    localparam logic [EVT_W-1:0] EVT_VALID = 12'h87F;
    localparam logic [7:0] OFF_STAT  = 8'h08;
    localparam logic [7:0] OFF_ENSET = 8'h10;
    localparam logic [7:0] OFF_ENCLR = 8'h14;
    localparam logic [7:0] OFF_HSTAT = 8'h00;
    localparam logic [7:0] OFF_HCTRL = 8'h04;
endpackage

// File: rtl/irqc_port_regs.sv
// One port's event latch, enable mask and steering field.
// Assumes wr_en is already qualified by the port's region decode.
// A same-cycle event wins over a clear of the same bit.
module irqc_port_regs
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_W-1:0]  evt,
    input  logic              wr_en,
    input  logic [7:0]        offset,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic [EVT_W-1:0]   raw_q;
    logic [EVT_W-1:0]   en_q;
    logic [STEER_W-1:0] steer_q;
    logic [EVT_W-1:0]   clr;
    logic [EVT_W-1:0]   masked;

    // Clear vector taken from both halves of a status write
    always_comb begin
        clr = '0;
        if (wr_en && offset == OFF_STAT)
            clr = wdata[EVT_W-1:0] | wdata[RAW_LSB +: EVT_W];
    end

    // Sticky event latch; new pulses are ORed after the clear
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (raw_q & ~clr) | (evt & EVT_VALID);
    end

    // Enable mask and steering field through set/clear offsets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            steer_q <= '0;
        end else if (wr_en && offset == OFF_ENSET) begin
            en_q    <= en_q | (wdata[EVT_W-1:0] & EVT_VALID);
            steer_q <= steer_q | wdata[STEER_LSB +: STEER_W];
        end else if (wr_en && offset == OFF_ENCLR) begin
            en_q    <= en_q & ~wdata[EVT_W-1:0];
            steer_q <= steer_q & ~wdata[STEER_LSB +: STEER_W];
        end
    end

    assign masked = raw_q & en_q;
    assign irq    = |masked;

    // Read mux for the port window
    always_comb begin
        rdata = '0;
        case (offset)
            OFF_STAT: begin
                rdata[EVT_W-1:0]       = masked;
                rdata[RAW_LSB +: EVT_W] = raw_q;
            end
            OFF_ENSET, OFF_ENCLR: begin
                rdata[EVT_W-1:0]           = en_q;
                rdata[STEER_LSB +: STEER_W] = steer_q;
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/irqc_host_regs.sv
// Host-level summary word and port enable mask.
// Assumes wr_en is qualified by the host region decode.
module irqc_host_regs
    import irqc_pkg::*;
#(
    parameter int N_PORTS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PORTS-1:0] port_irq,
    input  logic               wr_en,
    input  logic [7:0]         offset,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               host_irq
);
    logic [N_PORTS-1:0] ctrl_q;

    // Host port-enable mask register
    always_ff @(posedge clk) begin
        if (!rst_n)                         ctrl_q <= '0;
        else if (wr_en && offset == OFF_HCTRL) ctrl_q <= wdata[N_PORTS-1:0];
    end

    assign host_irq = |(port_irq & ctrl_q);

    // Read mux for the host window
    always_comb begin
        rdata = '0;
        case (offset)
            OFF_HSTAT: rdata[N_PORTS-1:0] = port_irq;
            OFF_HCTRL: rdata[N_PORTS-1:0] = ctrl_q;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/irqc_host_top.sv
// Top of the interrupt controller: region decode, one register
// block per port, host summary. Region 0 is the host, region p+1 port p.
module irqc_host_top
    import irqc_pkg::*;
#(
    parameter int N_PORTS    = 4,
    parameter int ADDR_W     = 12,
    parameter int REGION_LSB = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_PORTS*EVT_W-1:0] evt_pulse,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic [N_PORTS-1:0]       port_irq,
    output logic                     host_irq
);
    localparam int REG_W = ADDR_W - REGION_LSB;

    logic [REG_W-1:0]  region;
    logic [7:0]        offset;
    logic [DATA_W-1:0] port_rd [N_PORTS];
    logic [DATA_W-1:0] host_rd;

    assign region = bus_addr[ADDR_W-1:REGION_LSB];
    assign offset = 8'(bus_addr[REGION_LSB-1:0]);

    for (genvar g = 0; g < N_PORTS; g++) begin : g_port
        logic sel;
        assign sel = (region == REG_W'(g + 1));
        irqc_port_regs u_port (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (evt_pulse[g*EVT_W +: EVT_W]),
            .wr_en (bus_wr && sel),
            .offset(offset),
            .wdata (bus_wdata),
            .rdata (port_rd[g]),
            .irq   (port_irq[g])
        );
    end

    irqc_host_regs #(.N_PORTS(N_PORTS)) u_host (
        .clk     (clk),
        .rst_n   (rst_n),
        .port_irq(port_irq),
        .wr_en   (bus_wr && region == '0),
        .offset  (offset),
        .wdata   (bus_wdata),
        .rdata   (host_rd),
        .host_irq(host_irq)
    );

    // Read data select by region
    always_comb begin
        bus_rdata = (region == '0) ? host_rd : '0;
        for (int i = 0; i < N_PORTS; i++)
            if (region == REG_W'(i + 1)) bus_rdata = port_rd[i];
    end
endmodule

// File: rtl/irqc_host_chk.sv
// Port-level properties of the interrupt controller, bound to the top.
module irqc_host_chk #(
    parameter int N_PORTS = 4,
    parameter int ADDR_W  = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [N_PORTS*12-1:0] evt_pulse,
    input logic                  bus_wr,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [31:0]           bus_rdata,
    input logic [N_PORTS-1:0]    port_irq,
    input logic                  host_irq
);
    // R9
    host_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> (|port_irq));

    // R8
    summary_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == '0) |-> (bus_rdata == 32'(port_irq)));

    for (genvar g = 0; g < N_PORTS; g++) begin : g_chk
        // R2
        irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(port_irq[g]) |-> $past(bus_wr || (|evt_pulse[g*12 +: 12])));

        // R5
        irq_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(port_irq[g]) && $past(rst_n)) |-> $past(bus_wr));

        // R7
        irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!bus_wr && !(|evt_pulse[g*12 +: 12])) |=> $stable(port_irq[g]));
    end
endmodule

bind irqc_host_top irqc_host_chk #(.N_PORTS(N_PORTS), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_pulse(evt_pulse),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .port_irq (port_irq),
    .host_irq (host_irq)
);

// File: tb/irqc_host_top_test.sv
// Vector-table bench for the interrupt controller, plus directed tests.
module irqc_host_top_test;
    localparam int NP = 4;
    localparam logic [3:0] OWR = 4'd0, ORD = 4'd1, OEV = 4'd2, OIRQ = 4'd3;
    localparam int NV = 37;
    // {req, op, addr, data, expect}
    localparam logic [87:0] VEC [NV] = '{
        {4'd1,  ORD,  16'h108, 32'h0,          32'h0},          // R1
        {4'd1,  ORD,  16'h110, 32'h0,          32'h0},          // R1
        {4'd1,  OIRQ, 16'h0,   32'h0,          32'h0},          // R1
        {4'd2,  OEV,  16'h0,   32'h001,        32'h0},
        {4'd2,  ORD,  16'h108, 32'h0,          32'h0001_0000},  // R2
        {4'd4,  OWR,  16'h110, 32'h3,          32'h0},
        {4'd3,  ORD,  16'h108, 32'h0,          32'h0001_0001},  // R3
        {4'd4,  ORD,  16'h110, 32'h0,          32'h0000_0003},  // R4
        {4'd2,  OEV,  16'h0,   32'hFFF,        32'h0},
        {4'd2,  ORD,  16'h108, 32'h0,          32'h087F_0003},  // R2 R3
        {4'd5,  OWR,  16'h108, 32'h087F_0003,  32'h0},
        {4'd5,  ORD,  16'h108, 32'h0,          32'h0},          // R5
        {4'd4,  OWR,  16'h110, 32'hC000_0840,  32'h0},
        {4'd4,  ORD,  16'h110, 32'h0,          32'hC000_0843},  // R4
        {4'd4,  OWR,  16'h114, 32'h4000_0002,  32'h0},
        {4'd4,  ORD,  16'h114, 32'h0,          32'h8000_0841},  // R4
        {4'd4,  OWR,  16'h110, 32'h0000_0780,  32'h0},
        {4'd4,  ORD,  16'h110, 32'h0,          32'h8000_0841},  // R4
        {4'd10, OEV,  16'h1,   32'h800,        32'h0},
        {4'd10, ORD,  16'h208, 32'h0,          32'h0800_0000},  // R10
        {4'd10, ORD,  16'h108, 32'h0,          32'h0},          // R10
        {4'd10, ORD,  16'h10C, 32'h0,          32'h0},          // R10
        {4'd3,  OEV,  16'h0,   32'h040,        32'h0},
        {4'd3,  ORD,  16'h108, 32'h0,          32'h0040_0040},  // R3
        {4'd9,  OIRQ, 16'h0,   32'h0,          32'h01},         // R7 R9
        {4'd8,  ORD,  16'h000, 32'h0,          32'h1},          // R8
        {4'd9,  OWR,  16'h004, 32'hF,          32'h0},
        {4'd9,  ORD,  16'h004, 32'h0,          32'hF},          // R9
        {4'd9,  OIRQ, 16'h0,   32'h0,          32'h11},         // R9
        {4'd5,  OWR,  16'h108, 32'h0000_0040,  32'h0},
        {4'd7,  OIRQ, 16'h0,   32'h0,          32'h00},         // R5 R7
        {4'd7,  OWR,  16'h210, 32'h800,        32'h0},
        {4'd7,  OIRQ, 16'h0,   32'h0,          32'h12},         // R7
        {4'd9,  OWR,  16'h004, 32'h1,          32'h0},
        {4'd9,  OIRQ, 16'h0,   32'h0,          32'h02},         // R9
        {4'd8,  ORD,  16'h000, 32'h0,          32'h2},          // R8
        {4'd5,  OWR,  16'h208, 32'h0800_0000,  32'h0}           // R5 raw-half clear
    };

    logic           clk = 0;
    logic           rst_n = 0;
    logic [NP*12-1:0] evt_pulse = '0;
    logic           bus_wr = 0;
    logic [11:0]    bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NP-1:0]  port_irq;
    logic           host_irq;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irqc_host_top uut (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .port_irq(port_irq), .host_irq(host_irq)
    );

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic ev(input int p, input logic [11:0] bits);
        @(negedge clk);
        evt_pulse[p*12 +: 12] = bits;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic rd(input int req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1 check(req, bus_rdata, exp);
    endtask

    task automatic irqs(input int req, input logic [31:0] exp);
        @(negedge clk);
        #1 check(req, 32'({host_irq, port_irq}), exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        foreach (VEC[i]) begin
            case (VEC[i][83:80])
                OWR:  wr(VEC[i][75:64], VEC[i][63:32]);
                OEV:  ev(int'(VEC[i][75:64]), VEC[i][43:32]);
                ORD:  rd(int'(VEC[i][87:84]), VEC[i][75:64], VEC[i][31:0]);
                default: irqs(int'(VEC[i][87:84]), VEC[i][31:0]);
            endcase
        end
        rd(5, 12'h208, 32'h0); // R5 clear via raw half
        // R6: event and clear on the same bit in one cycle
        wr(12'h310, 32'h1);
        ev(2, 12'h001);
        @(negedge clk);
        bus_wr = 1; bus_addr = 12'h308; bus_wdata = 32'h0001_0001;
        evt_pulse[24 +: 12] = 12'h001;
        @(negedge clk);
        bus_wr = 0; evt_pulse = '0;
        rd(6, 12'h308, 32'h0001_0001); // R6
        // R9: mask zero, events still latch, host output stays low
        wr(12'h004, 32'h0);
        ev(3, 12'h002);
        wr(12'h410, 32'h2);
        rd(9, 12'h408, 32'h0002_0002);
        irqs(9, 32'h0C);                // R9
        // R1: reset mid-run clears everything
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        rd(1, 12'h408, 32'h0);
        rd(1, 12'h310, 32'h0);
        rd(1, 12'h004, 32'h0);
        irqs(1, 32'h0);                 // R1
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule